// File: doc/BRIEF.md
# ECC Error Capture and Control Register

This block is a 32-bit control and status register that sits beside the ECC checker of a parallel bus interface. It holds two control bits, the ECC/parity mode select and a switch that turns off single-bit correction. Both change only through a register write whose data word also carries a write-only update-enable bit. Writes without that bit leave them alone. After reset, the mode bit takes its value from a mode-strap input.

While bus traffic passes, the block watches the 4-bit command/byte-enable lines and keeps the raw nibble seen in each phase of the current transaction: first address, second address of a dual-address cycle, and attribute. When the ECC checker strobes an error, the block does two things at once. It commits those raw nibbles together with a nonzero error phase code into the register. It also classifies the error as corrected or uncorrectable, according to the mode and the correction switch. The phase code is cleared by a read. While it is nonzero, the captured fields are frozen.

Top module: `ecc_errcap_csr`

## Requirements
- R1: After reset release, bit 31 equals `mode_strap_i` (1 selects ECC mode, 0 parity mode). Bit 30, the capture fields [27:16] and the phase code [3:0] read 0.
- R2: A write with `reg_wdata_i[28]`=1 loads bits 31 and 30 from the written data. A write with bit 28 = 0 leaves both unchanged.
- R3: Bits 29 and 28 always read 0, as do bits 15:4.
- R4: One cycle after `err_strobe_i`, exactly one of `err_corrected_o` and `err_uncorrected_o` pulses. It is corrected only in ECC mode, with bit 30 = 0 and `err_correctable_i` = 1. With bit 30 = 1, a correctable error is reported as uncorrectable. With no strobe, both outputs are 0.
- R5: In parity mode (bit 31 = 0), bit 30 has no effect: every error is reported as uncorrectable.
- R6: A capture writes bits 19:16 with the raw nibble of the latest first-address phase (`ph_kind_i`=0). It writes bits 27:24 with the latest attribute phase nibble (`ph_kind_i`=2). Only phases seen before the strobe cycle count.
- R7: Bits 23:20 take the latest second-address nibble (`ph_kind_i`=1), but only when a second-address phase came after the latest first-address phase. Otherwise they are written 0.
- R8: A strobe with a nonzero `err_phase_i` while the phase code is 0 stores that code in bits 3:0 and captures. A strobe with code 0 captures nothing.
- R9: While the phase code is nonzero, further strobes change neither the phase code nor bits 27:16.
- R10: A read (`reg_rd_i`) clears the phase code on the next edge. A strobe in the same cycle as a read of a nonzero code is not captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode_strap_i | input | 1 | Reset value of the mode bit (1 = ECC) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (clears phase code) |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Register contents |
| ph_valid_i | input | 1 | A bus phase is present on `ph_cbe_i` |
| ph_kind_i | input | 2 | Phase kind: 0 first address, 1 second address, 2 attribute, 3 other |
| ph_cbe_i | input | 4 | Raw command/byte-enable nibble |
| err_strobe_i | input | 1 | ECC error flagged this cycle |
| err_phase_i | input | 4 | Error phase code to record |
| err_correctable_i | input | 1 | Checker judged the error single-bit correctable |
| ecc_mode_o | output | 1 | Current mode bit (1 = ECC) |
| err_corrected_o | output | 1 | Error will be corrected (one-cycle pulse) |
| err_uncorrected_o | output | 1 | Error reported as uncorrectable (one-cycle pulse) |

## Verification
Register fields change on the clock edge that ends the cycle of the write, read, phase or strobe. The report pulses also appear in the cycle after the strobe. Reset release takes two synchroniser stages plus one cycle to load the strap. The bench drives each stimulus on a falling edge. It advances its model at the following rising edge and samples all outputs one time unit later, so every field is compared in exactly the cycle it is due. Directed sequences cover dual-address capture, frozen captures, read-clear collisions and the mode/switch combinations. Random traffic follows them.

// File: rtl/ecc_csr_pkg.sv
package ecc_csr_pkg;
  localparam int REG_W      = 32;
  localparam int NIB_W      = 4;
  localparam int CODE_W     = 4;
  localparam int KIND_W     = 2;
  localparam int SLOTS      = 3;
  localparam int MODE_BIT   = 31;
  localparam int NOCORR_BIT = 30;
  localparam int UPD_BIT    = 28;
  localparam int ATTR_LSB   = 24;
  localparam int CMD2_LSB   = 20;
  localparam int CMD1_LSB   = 16;
  localparam int CODE_LSB   = 0;

  typedef enum logic [KIND_W-1:0] {
    PH_ADDR1 = 2'd0,
    PH_ADDR2 = 2'd1,
    PH_ATTR  = 2'd2,
    PH_OTHER = 2'd3
  } phase_kind_e;

  typedef struct packed {
    logic [NIB_W-1:0] attr;
    logic [NIB_W-1:0] cmd2;
    logic [NIB_W-1:0] cmd1;
  } cbe_set_t;
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/ecc_phase_hold.sv
module ecc_phase_hold
  import ecc_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ph_valid_i,
  input  logic [KIND_W-1:0] ph_kind_i,
  input  logic [NIB_W-1:0]  ph_cbe_i,
  output cbe_set_t          held_o
);
  logic [SLOTS-1:0][NIB_W-1:0] slots;
  logic dac_q;
  logic dac_d;
  logic dac_en;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic             hit;
    logic [NIB_W-1:0] nib_q;
    assign hit = ph_valid_i && (ph_kind_i == KIND_W'(s));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        nib_q <= '0;
      end else if (hit) begin
        nib_q <= ph_cbe_i;
      end
    end
    assign slots[s] = nib_q;
  end

  always_comb begin
    dac_en = 1'b0;
    dac_d  = dac_q;
    if (ph_valid_i && ph_kind_i == PH_ADDR1) begin
      dac_en = 1'b1;
      dac_d  = 1'b0;
    end else if (ph_valid_i && ph_kind_i == PH_ADDR2) begin
      dac_en = 1'b1;
      dac_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dac_q <= 1'b0;
    end else if (dac_en) begin
      dac_q <= dac_d;
    end
  end

  always_comb begin
    held_o.cmd1 = slots[PH_ADDR1];
    held_o.cmd2 = dac_q ? slots[PH_ADDR2] : '0;
    held_o.attr = slots[PH_ATTR];
  end
endmodule

// File: rtl/ecc_ctrl_bits.sv
module ecc_ctrl_bits (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strap_i,
  input  logic wr_i,
  input  logic upd_i,
  input  logic wmode_i,
  input  logic wnocorr_i,
  input  logic strobe_i,
  input  logic correctable_i,
  output logic mode_o,
  output logic nocorr_o,
  output logic strap_done_o,
  output logic corrected_o,
  output logic uncorrected_o
);
  logic mode_q, mode_d;
  logic nocorr_q, nocorr_d;
  logic done_q;
  logic ctrl_en;
  logic fix_ok;
  logic corr_q, corr_d;
  logic unc_q, unc_d;

  always_comb begin
    ctrl_en  = 1'b0;
    mode_d   = mode_q;
    nocorr_d = nocorr_q;
    if (!done_q) begin
      ctrl_en  = 1'b1;
      mode_d   = strap_i;
      nocorr_d = 1'b0;
    end else if (wr_i && upd_i) begin
      ctrl_en  = 1'b1;
      mode_d   = wmode_i;
      nocorr_d = wnocorr_i;
    end
  end

  always_comb begin
    fix_ok = mode_q && correctable_i && !nocorr_q;
    corr_d = strobe_i && fix_ok;
    unc_d  = strobe_i && !fix_ok;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q   <= 1'b0;
      nocorr_q <= 1'b0;
      done_q   <= 1'b0;
      corr_q   <= 1'b0;
      unc_q    <= 1'b0;
    end else begin
      if (ctrl_en) begin
        mode_q   <= mode_d;
        nocorr_q <= nocorr_d;
      end
      done_q <= 1'b1;
      corr_q <= corr_d;
      unc_q  <= unc_d;
    end
  end

  assign mode_o        = mode_q;
  assign nocorr_o      = nocorr_q;
  assign strap_done_o  = done_q;
  assign corrected_o   = corr_q;
  assign uncorrected_o = unc_q;
endmodule

// File: rtl/ecc_capture_regs.sv
module ecc_capture_regs
  import ecc_csr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strobe_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              rd_i,
  input  cbe_set_t          held_i,
  output cbe_set_t          cap_o,
  output logic [CODE_W-1:0] code_o
);
  cbe_set_t          cap_q;
  logic [CODE_W-1:0] code_q, code_d;
  logic              cap_en;
  logic              code_en;

  always_comb begin
    cap_en  = strobe_i && (code_i != '0) && (code_q == '0);
    code_en = cap_en || rd_i;
    code_d  = cap_en ? code_i : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_q  <= '0;
      code_q <= '0;
    end else begin
      if (cap_en) begin
        cap_q <= held_i;
      end
      if (code_en) begin
        code_q <= code_d;
      end
    end
  end

  assign cap_o  = cap_q;
  assign code_o = code_q;
endmodule

// File: rtl/ecc_errcap_csr.sv
module ecc_errcap_csr
  import ecc_csr_pkg::*;
#(
  parameter int RST_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_strap_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              ph_valid_i,
  input  logic [KIND_W-1:0] ph_kind_i,
  input  logic [NIB_W-1:0]  ph_cbe_i,
  input  logic              err_strobe_i,
  input  logic [CODE_W-1:0] err_phase_i,
  input  logic              err_correctable_i,
  output logic              ecc_mode_o,
  output logic              err_corrected_o,
  output logic              err_uncorrected_o
);
  logic              rst_sync_n;
  logic              mode;
  logic              nocorr;
  logic              strap_done;
  cbe_set_t          held;
  cbe_set_t          cap;
  logic [CODE_W-1:0] code;

  ecc_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_sync_n)
  );

  ecc_phase_hold u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .ph_valid_i(ph_valid_i),
    .ph_kind_i (ph_kind_i),
    .ph_cbe_i  (ph_cbe_i),
    .held_o    (held)
  );

  ecc_ctrl_bits u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .strap_i      (mode_strap_i),
    .wr_i         (reg_wr_i),
    .upd_i        (reg_wdata_i[UPD_BIT]),
    .wmode_i      (reg_wdata_i[MODE_BIT]),
    .wnocorr_i    (reg_wdata_i[NOCORR_BIT]),
    .strobe_i     (err_strobe_i),
    .correctable_i(err_correctable_i),
    .mode_o       (mode),
    .nocorr_o     (nocorr),
    .strap_done_o (strap_done),
    .corrected_o  (err_corrected_o),
    .uncorrected_o(err_uncorrected_o)
  );

  ecc_capture_regs u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .strobe_i(err_strobe_i),
    .code_i  (err_phase_i),
    .rd_i    (reg_rd_i),
    .held_i  (held),
    .cap_o   (cap),
    .code_o  (code)
  );

  always_comb begin
    reg_rdata_o                        = '0;
    reg_rdata_o[MODE_BIT]              = mode;
    reg_rdata_o[NOCORR_BIT]            = nocorr;
    reg_rdata_o[ATTR_LSB +: NIB_W]     = cap.attr;
    reg_rdata_o[CMD2_LSB +: NIB_W]     = cap.cmd2;
    reg_rdata_o[CMD1_LSB +: NIB_W]     = cap.cmd1;
    reg_rdata_o[CODE_LSB +: CODE_W]    = code;
  end

  assign ecc_mode_o = mode;
endmodule

// File: rtl/ecc_errcap_csr_chk.sv
module ecc_errcap_csr_chk (
  input logic        clk_i,
  input logic        rst_sync_n,
  input logic        strap_done,
  input logic        reg_wr_i,
  input logic        reg_rd_i,
  input logic [31:0] reg_wdata_i,
  input logic [31:0] reg_rdata_o,
  input logic        err_strobe_i,
  input logic [3:0]  err_phase_i,
  input logic        ecc_mode_o,
  input logic        err_corrected_o,
  input logic        err_uncorrected_o
);
  // R2
  ctrl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    strap_done && reg_wr_i && !reg_wdata_i[28] |=> $stable(reg_rdata_o[31:30]));

  // R2
  ctrl_load_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    strap_done && reg_wr_i && reg_wdata_i[28] |=> reg_rdata_o[31:30] == $past(reg_wdata_i[31:30]));

  // R3
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    reg_rdata_o[29:28] == 2'b00 && reg_rdata_o[15:4] == 12'h000);

  // R4
  report_one_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    err_strobe_i |=> $countones({err_corrected_o, err_uncorrected_o}) == 1);

  // R4
  report_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !err_strobe_i |=> !err_corrected_o && !err_uncorrected_o);

  // R5
  parity_nocorr_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !ecc_mode_o && err_strobe_i |=> !err_corrected_o);

  // R8
  zero_code_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    err_strobe_i && err_phase_i == 4'h0 && reg_rdata_o[3:0] == 4'h0 |=> reg_rdata_o[3:0] == 4'h0);

  // R9
  freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    reg_rdata_o[3:0] != 4'h0 && !reg_rd_i |=> $stable(reg_rdata_o[27:16]) && $stable(reg_rdata_o[3:0]));

  // R10
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    reg_rd_i && reg_rdata_o[3:0] != 4'h0 |=> reg_rdata_o[3:0] == 4'h0);
endmodule

bind ecc_errcap_csr ecc_errcap_csr_chk u_chk (
  .clk_i            (clk_i),
  .rst_sync_n       (rst_sync_n),
  .strap_done       (strap_done),
  .reg_wr_i         (reg_wr_i),
  .reg_rd_i         (reg_rd_i),
  .reg_wdata_i      (reg_wdata_i),
  .reg_rdata_o      (reg_rdata_o),
  .err_strobe_i     (err_strobe_i),
  .err_phase_i      (err_phase_i),
  .ecc_mode_o       (ecc_mode_o),
  .err_corrected_o  (err_corrected_o),
  .err_uncorrected_o(err_uncorrected_o)
);

// File: tb/ecc_errcap_csr_tb.sv
module ecc_errcap_csr_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        strap = 1'b1;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        pv = 1'b0;
  logic [1:0]  pk = '0;
  logic [3:0]  pc = '0;
  logic        es = 1'b0;
  logic [3:0]  ec = '0;
  logic        ecor = 1'b0;
  logic        mode_o, cor_o, unc_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic       m_mode, m_dis, m_cor, m_unc, hdac;
  logic [3:0] m_phase, m_c1, m_c2, m_at, h1, h2, ha;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_errcap_csr u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_strap_i(strap),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wd), .reg_rdata_o(rdata),
    .ph_valid_i(pv), .ph_kind_i(pk), .ph_cbe_i(pc),
    .err_strobe_i(es), .err_phase_i(ec), .err_correctable_i(ecor),
    .ecc_mode_o(mode_o), .err_corrected_o(cor_o), .err_uncorrected_o(unc_o)
  );

  function automatic logic fix_ok(logic md, logic ds, logic cr);
    return md && cr && !ds;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_all();
    chk("R1 mode pin", {31'd0, mode_o}, {31'd0, m_mode});
    chk("R2 ctrl bits", {30'd0, rdata[31:30]}, {30'd0, m_mode, m_dis});
    chk("R3 reserved", {18'd0, rdata[29:28], rdata[15:4]}, '0);
    chk("R4 report", {30'd0, cor_o, unc_o}, {30'd0, m_cor, m_unc});
    chk("R6 capture", {20'd0, rdata[27:16]}, {20'd0, m_at, m_c2, m_c1});
    chk("R8 phase code", {28'd0, rdata[3:0]}, {28'd0, m_phase});
  endtask

  task automatic cyc(logic iwr, logic ird, logic [31:0] iwd, logic ipv, logic [1:0] ipk,
                     logic [3:0] ipc, logic ies, logic [3:0] iec, logic icor);
    logic cap;
    @(negedge clk);
    wr = iwr; rd = ird; wd = iwd; pv = ipv; pk = ipk; pc = ipc;
    es = ies; ec = iec; ecor = icor;
    @(posedge clk);
    #1;
    m_cor = ies && fix_ok(m_mode, m_dis, icor);
    m_unc = ies && !fix_ok(m_mode, m_dis, icor);
    if (iwr && iwd[28]) begin m_mode = iwd[31]; m_dis = iwd[30]; end
    cap = ies && (iec != 4'h0) && (m_phase == 4'h0);
    if (cap) begin
      m_c1 = h1; m_c2 = hdac ? h2 : 4'h0; m_at = ha; m_phase = iec;
    end else if (ird) begin
      m_phase = 4'h0;
    end
    if (ipv) begin
      case (ipk)
        2'd0: begin h1 = ipc; hdac = 1'b0; end
        2'd1: begin h2 = ipc; hdac = 1'b1; end
        2'd2: ha = ipc;
        default: ;
      endcase
    end
    chk_all();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, '0, 0, 2'd3, 4'h0, 0, 4'h0, 0);
  endtask

  task automatic do_reset(logic s);
    @(negedge clk);
    rst_ni = 1'b0; strap = s;
    wr = 0; rd = 0; wd = '0; pv = 0; pk = 2'd3; pc = '0; es = 0; ec = '0; ecor = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    m_mode = s; m_dis = 1'b0; m_cor = 1'b0; m_unc = 1'b0;
    m_phase = '0; m_c1 = '0; m_c2 = '0; m_at = '0;
    h1 = '0; h2 = '0; ha = '0; hdac = 1'b0;
    // R1: reset state with the strap value
    chk("R1 reset word", rdata, {s, 31'd0});
    chk_all();
  endtask

  task automatic ph(logic [1:0] k, logic [3:0] v);
    cyc(0, 0, '0, 1, k, v, 0, 4'h0, 0);
  endtask

  task automatic strobe(logic [3:0] code, logic cr);
    cyc(0, 0, '0, 0, 2'd3, 4'h0, 1, code, cr);
  endtask

  task automatic rd_reg();
    cyc(0, 1, '0, 0, 2'd3, 4'h0, 0, 4'h0, 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset(1'b1);
    idle(2);

    // R2: write without update enable leaves control bits alone
    cyc(1, 0, 32'h4000_0000, 0, 2'd3, 0, 0, 0, 0);
    chk("R2 gated write", {30'd0, rdata[31:30]}, {30'd0, 2'b10});
    cyc(1, 0, 32'h5000_0000, 0, 2'd3, 0, 0, 0, 0);
    chk("R2 enabled write", {30'd0, rdata[31:30]}, {30'd0, 2'b01});
    // R3: update bit not readable
    chk("R3 update bit", {31'd0, rdata[28]}, '0);

    // R5: parity mode, switch set or clear, correctable -> uncorrectable
    strobe(4'h0, 1);
    chk("R5 parity sw1", {30'd0, cor_o, unc_o}, {30'd0, 2'b01});
    cyc(1, 0, 32'h1000_0000, 0, 2'd3, 0, 0, 0, 0);
    strobe(4'h0, 1);
    chk("R5 parity sw0", {30'd0, cor_o, unc_o}, {30'd0, 2'b01});

    // R4: ECC mode, correction on, then off
    cyc(1, 0, 32'h9000_0000, 0, 2'd3, 0, 0, 0, 0);
    strobe(4'h0, 1);
    chk("R4 corrected", {30'd0, cor_o, unc_o}, {30'd0, 2'b10});
    idle(1);
    chk("R4 idle", {30'd0, cor_o, unc_o}, '0);
    cyc(1, 0, 32'hD000_0000, 0, 2'd3, 0, 0, 0, 0);
    strobe(4'h0, 1);
    chk("R4 switch off", {30'd0, cor_o, unc_o}, {30'd0, 2'b01});
    // R8: code 0 captures nothing
    chk("R8 zero code", {28'd0, rdata[3:0]}, '0);

    // R6/R7: dual address transaction
    ph(2'd0, 4'hA); ph(2'd1, 4'h5); ph(2'd2, 4'hC);
    strobe(4'h3, 0);
    chk("R7 dual addr", {20'd0, rdata[27:16]}, {20'd0, 12'hC5A});
    chk("R8 code kept", {28'd0, rdata[3:0]}, 32'h3);
    // R9: frozen while code nonzero
    ph(2'd0, 4'h7); ph(2'd2, 4'h1);
    strobe(4'h9, 1);
    chk("R9 frozen", {20'd0, rdata[27:16]}, {20'd0, 12'hC5A});
    chk("R9 code frozen", {28'd0, rdata[3:0]}, 32'h3);
    // R10: read clears
    rd_reg();
    chk("R10 cleared", {28'd0, rdata[3:0]}, '0);
    // R7: single address since last first phase -> second field 0
    strobe(4'h2, 0);
    chk("R7 single addr", {20'd0, rdata[27:16]}, {20'd0, 12'h107});
    // R10: read collides with strobe while code nonzero
    cyc(0, 1, '0, 0, 2'd3, 0, 1, 4'h6, 0);
    chk("R10 collide", {28'd0, rdata[3:0]}, '0);
    // R6: phase in strobe cycle not included
    ph(2'd0, 4'h4);
    cyc(0, 0, '0, 1, 2'd0, 4'hE, 1, 4'h5, 0);
    chk("R6 same cycle", {28'd0, rdata[19:16]}, 32'h4);
    rd_reg();

    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[3:0] == 0, r[7:4] < 3, $urandom, r[11:8] < 10, r[13:12], r[17:14],
          r[21:18] < 3, (r[22] ? r[26:23] : 4'h0), r[27]);
    end

    do_reset(1'b0);
    // R1: parity strap
    chk("R1 strap low", {31'd0, mode_o}, '0);
    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      cyc(r[3:0] == 0, r[7:4] < 3, $urandom, r[11:8] < 10, r[13:12], r[17:14],
          r[21:18] < 3, (r[22] ? r[26:23] : 4'h0), r[27]);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule